// File: doc/BRIEF.md
# Multi-Mode DMA Transfer Controller

This block moves blocks of words between a peripheral and system memory without the CPU taking part. It has eight independent channels. Each channel holds a 16-bit memory address, a 16-bit word count and a small control word. The CPU programs a channel through a simple register port and then arms it. From then on the controller requests the system bus, runs the transfer and raises an interrupt when the block is finished.

A single sequencer serves all channels and has three bus-ownership policies, chosen per channel. In transparent mode the bus is held, but it is driven only in cycles where the CPU reports that it is idle. In cycle-steal mode the bus is handed back after every word and stays released for a programmable gap. In burst mode the bus is kept from the first word to the last. Every word takes two bus cycles: a read from the source, then a write to the destination. A direction bit picks which side is the source. When several channels are armed, a fixed priority decides which one runs, and it decides only between bus tenures.

Register port: `cfg_field` selects what `cfg_sel` addresses. 0 is the memory address, 1 is the word count, 2 is the control word, and 3 is the status vector, which is shared by all channels. The control word bits are: bit 0 arm, bits 2:1 mode (00 transparent, 01 cycle-steal, 10 or 11 burst), bit 3 direction (0 peripheral-to-memory, 1 memory-to-peripheral), bits 5:4 steal gap G, and bit 6 interrupt enable. Reading field 2 returns these fields with bit 0 showing whether the channel is active. Reading field 3 returns the done bits in bits 7:0 and the active bits in bits 15:8. Writing field 3 clears every done bit whose `cfg_wdata` bit is 1.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset every channel's address, count, control word and status read back as zero, and `bus_req` and `irq` are low.
- R2: Fields 0 to 2 of an idle channel take the value written and read it back. While a channel is active, writes to its fields 0 to 2 have no effect.
- R3: Each word is one read strobe from the source followed by one write strobe to the destination that carries the word just read. With direction 0 the source is the peripheral (`bus_io`=1) and the destination is memory. With direction 1 the roles are reversed. A peripheral cycle puts the channel number on `bus_addr`.
- R4: After each word the channel's address rises by one and its count falls by one. The word written while the count is zero is the last one, so a block is count+1 words, and the count then reads 0xFFFF.
- R5: `bus_rd` and `bus_wr` are asserted only while `bus_gnt` is high. `bus_req` falls exactly one cycle after the last write strobe of a tenure.
- R6: In transparent mode no strobe occurs in a cycle where `cpu_idle` is low. The transfer stalls and resumes in later idle cycles.
- R7: In cycle-steal mode each tenure moves exactly one word. With no other channel pending, `bus_req` stays low for G+1 cycles between words.
- R8: In burst mode `bus_req` stays high, without a break, from the first word of the block to its last.
- R9: Among armed channels the lowest-numbered one wins. The choice is made only when the bus is free, so a running burst is never interrupted by a higher-priority channel.
- R10: A channel's done bit sets when its block completes and stays set until a 1 is written to its bit in field 3. Writing 0 leaves it unchanged.
- R11: `irq` is high exactly when some channel has both its done bit and its interrupt enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Channel selected for register access |
| cfg_field | input | 2 | Field selected for register access |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| cpu_idle | input | 1 | CPU does not need the bus this cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_io | output | 1 | Current strobe targets the peripheral (1) or memory (0) |
| bus_addr | output | 16 | Memory address, or channel number for peripheral cycles |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled at the end of a read strobe cycle |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a collision in which a higher-priority channel is armed while a lower-priority burst already owns the bus. The bench starts a long burst on channel 6. Within the next few cycles it arms channel 5 and then channel 2, and it also tries to overwrite channel 6's address in the middle of the transfer. The order of memory writes has to show every channel 6 word first, then channel 2 and then channel 5, and channel 6's address has to read back as its own final value. Transparent stalls are forced by driving `cpu_idle` high only one cycle in three.

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int CW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [$clog2(NCH)-1:0] cfg_sel,
  input  logic [1:0]             cfg_field,
  input  logic [DW-1:0]          cfg_wdata,
  output logic [DW-1:0]          cfg_rdata,
  output logic                   bus_req,
  input  logic                   bus_gnt,
  input  logic                   cpu_idle,
  output logic                   bus_rd,
  output logic                   bus_wr,
  output logic                   bus_io,
  output logic [AW-1:0]          bus_addr,
  output logic [DW-1:0]          bus_wdata,
  input  logic [DW-1:0]          bus_rdata,
  output logic                   irq
);
  localparam int CHW = $clog2(NCH);
  localparam logic [1:0] M_TRANS = 2'b00;
  localparam logic [1:0] M_STEAL = 2'b01;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_GAP} st_t;

  logic [AW-1:0] addr_q [NCH];
  logic [CW-1:0] cnt_q  [NCH];
  logic [1:0]    mode_q [NCH];
  logic [1:0]    gap_q  [NCH];
  logic [NCH-1:0] dir_q, ien_q, active, done;

  st_t            state;
  logic [CHW-1:0] cur, pick;
  logic           any;
  logic [DW-1:0]  hold_q;
  logic [1:0]     gap_cnt;

  wire [1:0] cur_mode = mode_q[cur];
  wire       go       = bus_gnt && (cur_mode != M_TRANS || cpu_idle);
  wire       last     = (cnt_q[cur] == '0);
  wire       src_io   = !dir_q[cur];
  wire       word_end = bus_wr;

  assign bus_req   = (state == S_REQ) || (state == S_RD) || (state == S_WR);
  assign bus_rd    = (state == S_RD) && go;
  assign bus_wr    = (state == S_WR) && go;
  assign bus_io    = (state == S_RD) ? src_io : (state == S_WR) ? !src_io : 1'b0;
  assign bus_addr  = bus_io ? AW'(cur) : addr_q[cur];
  assign bus_wdata = bus_wr ? hold_q : '0;
  assign irq       = |(done & ien_q);

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (active[i]) begin
        pick = CHW'(i);
        any  = 1'b1;
      end
    end
  end

  always_comb begin
    case (cfg_field)
      2'd0:    cfg_rdata = DW'(addr_q[cfg_sel]);
      2'd1:    cfg_rdata = DW'(cnt_q[cfg_sel]);
      2'd2:    cfg_rdata = DW'({ien_q[cfg_sel], gap_q[cfg_sel], dir_q[cfg_sel],
                                mode_q[cfg_sel], active[cfg_sel]});
      default: cfg_rdata = DW'({active, done});
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        mode_q[i] <= '0;
        gap_q[i]  <= '0;
      end
      dir_q  <= '0;
      ien_q  <= '0;
      active <= '0;
      done   <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (cfg_wr && cfg_sel == CHW'(i) && !active[i]) begin
          case (cfg_field)
            2'd0: addr_q[i] <= cfg_wdata[AW-1:0];
            2'd1: cnt_q[i]  <= cfg_wdata[CW-1:0];
            2'd2: begin
              active[i] <= cfg_wdata[0];
              mode_q[i] <= cfg_wdata[2:1];
              dir_q[i]  <= cfg_wdata[3];
              gap_q[i]  <= cfg_wdata[5:4];
              ien_q[i]  <= cfg_wdata[6];
            end
            default: ;
          endcase
        end
      end
      if (cfg_wr && cfg_field == 2'd3)
        done <= done & ~cfg_wdata[NCH-1:0];
      if (word_end) begin
        addr_q[cur] <= addr_q[cur] + 1'b1;
        cnt_q[cur]  <= cnt_q[cur] - 1'b1;
        if (last) begin
          active[cur] <= 1'b0;
          done[cur]   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= '0;
      hold_q  <= '0;
      gap_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (any) begin
          cur   <= pick;
          state <= S_REQ;
        end
        S_REQ: if (bus_gnt) state <= S_RD;
        S_RD: if (go) begin
          hold_q <= bus_rdata;
          state  <= S_WR;
        end
        S_WR: if (go) begin
          if (last) state <= S_IDLE;
          else if (cur_mode == M_STEAL) begin
            if (gap_q[cur] == 2'd0) state <= S_IDLE;
            else begin
              gap_cnt <= gap_q[cur];
              state   <= S_GAP;
            end
          end else state <= S_RD;
        end
        S_GAP: begin
          if (gap_cnt == 2'd1) state <= S_IDLE;
          gap_cnt <= gap_cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  strobe_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_gnt);

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(bus_wr));

  // R6
  trans_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && cur_mode == M_TRANS) |-> cpu_idle);

  // R7
  steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cur_mode == M_STEAL) |=> !bus_req);

  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cur_mode[1] && !last) |=> bus_req);

  // R9
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> $stable(cur));

  // R4
  block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && last) |=> (done[cur] && !active[cur]));
endmodule

// File: tb/dma_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module dma_xfer_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [2:0]  cfg_sel = 0;
  logic [1:0]  cfg_field = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic        bus_req, bus_gnt, bus_rd, bus_wr, bus_io, irq;
  logic        cpu_idle = 1;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;

  logic [15:0] mem [256];
  logic [15:0] wlog [64];
  logic [15:0] iolog [16];
  int          wn = 0, ion = 0;
  logic [15:0] pcnt = 0;
  bit          gnt_allow = 1;
  bit          tp_en = 0;
  int          n_chk = 0, n_fail = 0;
  bit          reported = 0;
  int          w_rise, w_fall, w_lowmin, w_lowmax, w_stall, w_viol;

  always #2.5 clk = ~clk;

  dma_xfer_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .cpu_idle(cpu_idle),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  assign bus_rdata = bus_io ? (16'hC000 + pcnt) : mem[bus_addr[7:0]];

  initial begin
    bus_gnt = 0;
    forever begin
      @(posedge clk); #1;
      bus_gnt = bus_req && gnt_allow;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n && bus_wr && !bus_io) begin
      mem[bus_addr[7:0]] = bus_wdata;
      wlog[wn[5:0]] = bus_addr;
      wn++;
      pcnt++;
    end
    if (rst_n && bus_wr && bus_io) begin
      iolog[ion[3:0]] = bus_wdata;
      ion++;
    end
  end

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    end
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_w(input int sel, input int fld, input logic [15:0] d);
    @(negedge clk);
    cfg_sel = sel[2:0]; cfg_field = fld[1:0]; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_r(input int sel, input int fld, output logic [15:0] d);
    @(negedge clk);
    cfg_sel = sel[2:0]; cfg_field = fld[1:0];
    #1 d = cfg_rdata;
  endtask

  task automatic run_watch(input int ch, input int maxc);
    logic prev = 0;
    bit   seen = 0, fin = 0;
    int   low = 0;
    w_rise = 0; w_fall = 0; w_lowmin = 1000; w_lowmax = 0; w_stall = 0; w_viol = 0;
    cfg_sel = ch[2:0]; cfg_field = 2'd3;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (bus_req && !prev) begin
        w_rise++;
        if (seen) begin
          if (low < w_lowmin) w_lowmin = low;
          if (low > w_lowmax) w_lowmax = low;
        end
      end
      if (!bus_req && prev) w_fall++;
      if (bus_req) begin low = 0; seen = 1; end else low++;
      if ((bus_rd || bus_wr) && !cpu_idle) w_viol++;
      if (bus_req && bus_gnt && !cpu_idle && !bus_rd && !bus_wr) w_stall++;
      prev = bus_req;
      if (cfg_rdata[ch]) begin fin = 1; break; end
      @(posedge clk); #1;
      if (tp_en) cpu_idle = (c % 3 == 2);
    end
    cpu_idle = 1;
    chk("completion within time limit", fin, 1);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 bus_req low in reset", bus_req, 0);
    chk("R1 irq low in reset", irq, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    cfg_r(0, 0, d); chk("R1 address reset", d, 0);
    cfg_r(7, 1, d); chk("R1 count reset", d, 0);
    cfg_r(4, 2, d); chk("R1 control reset", d, 0);
    cfg_r(0, 3, d); chk("R1 status reset", d, 0);
  endtask

  task automatic t_burst();
    logic [15:0] d;
    pcnt = 0;
    cfg_w(3, 0, 16'h0010);
    cfg_w(3, 1, 16'h0002);
    cfg_r(3, 0, d); chk("R2 address readback", d, 16'h0010);
    cfg_r(3, 1, d); chk("R2 count readback", d, 16'h0002);
    cfg_w(3, 2, 16'h0045);
    run_watch(3, 200);
    chk("R8 burst single request rise", w_rise, 1);
    chk("R8 burst single request fall", w_fall, 1);
    chk("R3 word0 from peripheral", mem[8'h10], 16'hC000);
    chk("R3 word1 from peripheral", mem[8'h11], 16'hC001);
    chk("R4 word2 last word", mem[8'h12], 16'hC002);
    chk("R4 nothing past block", wn, 3);
    cfg_r(3, 0, d); chk("R4 final address", d, 16'h0013);
    cfg_r(3, 1, d); chk("R4 final count", d, 16'hFFFF);
    cfg_r(3, 2, d); chk("R2 control readback idle", d, 16'h0044);
    cfg_r(3, 3, d); chk("R10 done bit set", d, 16'h0008);
    chk("R11 irq with enabled done", irq, 1);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    cfg_w(0, 3, 16'h0000);
    cfg_r(0, 3, d); chk("R10 writing zero keeps done", d, 16'h0008);
    cfg_w(0, 3, 16'h0008);
    cfg_r(0, 3, d); chk("R10 write one clears done", d, 16'h0000);
    chk("R11 irq drops after clear", irq, 0);
  endtask

  task automatic t_steal();
    logic [15:0] d;
    mem[8'h20] = 16'h1111;
    mem[8'h21] = 16'h2222;
    ion = 0;
    cfg_w(1, 0, 16'h0020);
    cfg_w(1, 1, 16'h0001);
    cfg_w(1, 2, 16'h002B);
    run_watch(1, 200);
    chk("R7 one tenure per word", w_rise, 2);
    chk("R7 gap min G+1", w_lowmin, 3);
    chk("R7 gap max G+1", w_lowmax, 3);
    chk("R3 peripheral writes", ion, 2);
    chk("R3 first word to peripheral", iolog[0], 16'h1111);
    chk("R3 second word to peripheral", iolog[1], 16'h2222);
    cfg_r(1, 0, d); chk("R4 steal final address", d, 16'h0022);
    cfg_r(1, 3, d); chk("R10 steal done bit", d, 16'h0002);
    chk("R11 irq masked when disabled", irq, 0);
    cfg_w(1, 3, 16'h0002);
  endtask

  task automatic t_trans();
    pcnt = 0;
    cfg_w(0, 0, 16'h0080);
    cfg_w(0, 1, 16'h0003);
    tp_en = 1;
    cfg_w(0, 2, 16'h0041);
    run_watch(0, 400);
    tp_en = 0;
    chk("R6 no strobe while CPU busy", w_viol, 0);
    chk("R6 stall observed", (w_stall > 0) ? 1 : 0, 1);
    chk("R6 word0", mem[8'h80], 16'hC000);
    chk("R6 word3", mem[8'h83], 16'hC003);
    chk("R11 irq after transparent block", irq, 1);
    cfg_w(0, 3, 16'h0001);
  endtask

  task automatic t_prio();
    logic [15:0] d;
    wn = 0;
    cfg_w(6, 0, 16'h0040); cfg_w(6, 1, 16'h0003);
    cfg_w(5, 0, 16'h0060); cfg_w(5, 1, 16'h0000);
    cfg_w(2, 0, 16'h0050); cfg_w(2, 1, 16'h0000);
    cfg_w(6, 2, 16'h0005);
    cfg_w(5, 2, 16'h0005);
    cfg_w(2, 2, 16'h0005);
    cfg_w(6, 0, 16'h0077);
    run_watch(5, 300);
    chk("R9 total words", wn, 6);
    chk("R9 burst word0", wlog[0], 16'h0040);
    chk("R9 burst not preempted", wlog[3], 16'h0043);
    chk("R9 channel 2 before 5", wlog[4], 16'h0050);
    chk("R9 channel 5 last", wlog[5], 16'h0060);
    cfg_r(6, 0, d); chk("R2 write to active channel ignored", d, 16'h0044);
    cfg_r(6, 1, d); chk("R4 burst count wraps", d, 16'hFFFF);
    cfg_r(0, 3, d); chk("R10 three done bits", d, 16'h0064);
  endtask

  initial begin
    t_reset();
    t_burst();
    t_clear();
    t_steal();
    t_trans();
    t_prio();
    summary();
    $finish;
  end
endmodule